// File: doc/BRIEF.md
# Infrared Run-Length Sampler

This block watches the output of a consumer-infrared receiver module and turns the demodulated waveform into a stream of one-byte run-length codes. A slow sample strobe from outside the block sets the time base. At each strobe the block takes one sample of the synchronized input. It can flip the sense of that sample, because receiver modules usually drive an active-low output. Short level changes are discarded as noise. The block counts how many samples the cleaned level holds. When the level changes, the finished run is reported as a code. Bit 7 of the code is the level and the low seven bits are the length.

A packet is closed when the line rests at the idle (space) level for longer than a programmable number of samples. The block then raises a one-cycle packet-end pulse. It emits nothing more until the line next goes to the active (pulse) level. Software or a downstream decoder reads the codes and rebuilds the timing of the remote-control frame. Decoding a protocol and removing the carrier are left to other logic.

Top module: `ir_rl_sampler`

## Requirements
- R1: The sampler runs only while `glob_en` and `rx_en` are both 1 and `mode` equals 2'b11. In any other case it emits no code and no packet end, and its state returns to the reset state (idle, space level, counters cleared).
- R2: The sampled level is `ir_in` XOR `invert`. Level 1 is the active (pulse) level and level 0 is the idle (space) level.
- R3: Each finished run is reported as an 8-bit code. Bit 7 is the run's level and bits 6:0 are the run length in samples minus one. `code_valid` is high for one clock, two clock edges after the edge that sampled the strobe which ended the run.
- R4: The cleaned level changes only after `noise_thr`+1 consecutive samples differ from it. A shorter excursion is absorbed into the ongoing run. With `noise_thr` = 0, every change is accepted at once.
- R5: A run of either level that reaches 129 samples is split. A code with length field 0x7F is emitted, and the sample that triggered the split counts as the first sample of a new run of the same level.
- R6: When a space run grows to `idle_thr`+1 samples, `pkt_end` pulses for one clock, with the same latency as a code. The trailing space is not emitted. A packet end takes precedence over a split on the same sample. The sample that begins a space run never triggers a packet end, so an `idle_thr` of 0 acts like 1.
- R7: After reset, after re-enable and after a packet end, no code is emitted until the cleaned level becomes 1. The leading idle is never reported.
- R8: `code_valid` and `pkt_end` are never high together. The packet end comes after the last code of its packet.
- R9: While `rst_n` is low, `code_valid`, `pkt_end` and `code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-clock sample strobe (for example clock divided to 125 kHz) |
| ir_in | input | 1 | Raw receiver output, asynchronous |
| glob_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive path enable |
| mode | input | 2 | Operating mode; 2'b11 selects run-length capture |
| invert | input | 1 | Flip input sense before sampling |
| noise_thr | input | NTHR_W (6) | Glitch rejection length in samples |
| idle_thr | input | ITHR_W (8) | Idle length in samples that ends a packet |
| code | output | LEN_W+1 (8) | Level bit and run length minus one |
| code_valid | output | 1 | One-clock strobe qualifying `code` |
| pkt_end | output | 1 | One-clock packet-end pulse |

## Verification
Every result appears exactly two clock edges after the edge that took in the sample strobe that caused it. There is one edge in the filter stage and one in the run counter. The input synchronizer adds two more edges before a new `ir_in` value can be sampled. The driver therefore changes `ir_in` three clocks before each strobe. The monitor records how many edges have passed since the last strobe and flags any code or packet end that arrives at any other offset. Expected codes and packet-end markers are queued in order by the stimulus tasks. Each scenario ends by waiting past the last due cycle and confirming that the queue is empty.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;
    // Mode value that selects run-length capture.
    localparam logic [1:0] MODE_CIR = 2'b11;
    // Level meanings after the polarity stage.
    localparam logic LVL_PULSE = 1'b1;
    localparam logic LVL_SPACE = 1'b0;
endpackage

// File: rtl/ir_rl_sync.sv
module ir_rl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/ir_rl_filter.sv
module ir_rl_filter #(
    parameter int NTHR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              level_in,
    input  logic [NTHR_W-1:0] noise_thr,
    output logic              flt_o,
    output logic              stb_o
);
    localparam int PEND_W = NTHR_W + 1;

    typedef struct packed {
        logic              flt;
        logic [PEND_W-1:0] pend;
        logic              stb;
    } flt_t;

    flt_t q, d;
    logic [PEND_W-1:0] pend_inc;

    always_comb begin
        d        = q;
        d.stb    = 1'b0;
        pend_inc = q.pend + 1'b1;
        if (!run) begin
            d.flt  = 1'b0;
            d.pend = '0;
        end else if (tick) begin
            d.stb = 1'b1;
            if (level_in == q.flt) begin
                d.pend = '0;
            end else if (pend_inc > {1'b0, noise_thr}) begin
                d.flt  = level_in;
                d.pend = '0;
            end else begin
                d.pend = pend_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flt_o = q.flt;
    assign stb_o = q.stb;
endmodule

// File: rtl/ir_rl_runlen.sv
module ir_rl_runlen #(
    parameter int LEN_W  = 7,
    parameter int ITHR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              stb,
    input  logic              flt,
    input  logic [ITHR_W-1:0] idle_thr,
    output logic [LEN_W:0]    code,
    output logic              code_valid,
    output logic              pkt_end
);
    import ir_rl_pkg::*;

    localparam int ICNT_W = ITHR_W + 1;
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    typedef struct packed {
        logic              lvl;
        logic              idle;
        logic [LEN_W-1:0]  len;
        logic [ICNT_W-1:0] icnt;
        logic [LEN_W:0]    code;
        logic              valid;
        logic              pe;
    } rl_t;

    localparam rl_t RL_RESET = '{lvl: LVL_SPACE, idle: 1'b1, len: '0,
                                 icnt: '0, code: '0, valid: 1'b0, pe: 1'b0};

    rl_t q, d;
    logic [ICNT_W-1:0] icnt_inc;

    always_comb begin
        d        = q;
        d.valid  = 1'b0;
        d.pe     = 1'b0;
        icnt_inc = q.icnt + 1'b1;
        if (!run) begin
            d = RL_RESET;
        end else if (stb) begin
            if (q.idle) begin
                // Wait for the first active sample; idle is never reported.
                if (flt == LVL_PULSE) begin
                    d.idle = 1'b0;
                    d.lvl  = LVL_PULSE;
                    d.len  = '0;
                    d.icnt = '0;
                end
            end else if (flt != q.lvl) begin
                // Level change: report the finished run, start a new one.
                d.code  = {q.lvl, q.len};
                d.valid = 1'b1;
                d.lvl   = flt;
                d.len   = '0;
                d.icnt  = (flt == LVL_SPACE) ? ICNT_W'(1) : '0;
            end else if ((q.lvl == LVL_SPACE) && (icnt_inc > {1'b0, idle_thr})) begin
                // Idle long enough: close the packet, drop the trailing space.
                d.pe   = 1'b1;
                d.idle = 1'b1;
                d.lvl  = LVL_SPACE;
                d.len  = '0;
                d.icnt = '0;
            end else begin
                if (q.lvl == LVL_SPACE) d.icnt = icnt_inc;
                if (q.len == LEN_MAX) begin
                    d.code  = {q.lvl, LEN_MAX};
                    d.valid = 1'b1;
                    d.len   = '0;
                end else begin
                    d.len = q.len + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RL_RESET;
        else        q <= d;
    end

    assign code       = q.code;
    assign code_valid = q.valid;
    assign pkt_end    = q.pe;
endmodule

// File: rtl/ir_rl_sampler.sv
module ir_rl_sampler #(
    parameter int NTHR_W      = 6,
    parameter int ITHR_W      = 8,
    parameter int LEN_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              ir_in,
    input  logic              glob_en,
    input  logic              rx_en,
    input  logic [1:0]        mode,
    input  logic              invert,
    input  logic [NTHR_W-1:0] noise_thr,
    input  logic [ITHR_W-1:0] idle_thr,
    output logic [LEN_W:0]    code,
    output logic              code_valid,
    output logic              pkt_end
);
    import ir_rl_pkg::*;

    logic run;
    logic ir_sync;
    logic level;
    logic flt;
    logic flt_stb;

    assign run   = glob_en & rx_en & (mode == MODE_CIR);

    ir_rl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ir_in),
        .dout  (ir_sync)
    );

    assign level = ir_sync ^ invert;

    ir_rl_filter #(.NTHR_W(NTHR_W)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (sample_tick),
        .level_in  (level),
        .noise_thr (noise_thr),
        .flt_o     (flt),
        .stb_o     (flt_stb)
    );

    ir_rl_runlen #(.LEN_W(LEN_W), .ITHR_W(ITHR_W)) u_runlen (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .stb        (flt_stb),
        .flt        (flt),
        .idle_thr   (idle_thr),
        .code       (code),
        .code_valid (code_valid),
        .pkt_end    (pkt_end)
    );
endmodule

// File: rtl/ir_rl_checker.sv
module ir_rl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sample_tick,
    input logic       glob_en,
    input logic       rx_en,
    input logic [1:0] mode,
    input logic       code_valid,
    input logic       pkt_end
);
    logic running;
    assign running = glob_en && rx_en && (mode == 2'b11);

    // R8: code and packet end never share a cycle
    assert_no_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_valid && pkt_end));

    // R3: a code follows a sample strobe by exactly two edges
    assert_code_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $past(sample_tick, 2));

    // R6: packet end follows a sample strobe by exactly two edges
    assert_pe_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> $past(sample_tick, 2));

    // R6: packet end lasts a single clock
    assert_pe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !pkt_end);

    // R1: nothing is produced unless the block was running through both stages
    assert_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid || pkt_end) |-> ($past(running, 1) && $past(running, 2)));
endmodule

bind ir_rl_sampler ir_rl_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .glob_en     (glob_en),
    .rx_en       (rx_en),
    .mode        (mode),
    .code_valid  (code_valid),
    .pkt_end     (pkt_end)
);

// File: tb/test_ir_rl_sampler.sv
module test_ir_rl_sampler;
    localparam int CLK_PERIOD = 10;
    localparam logic [8:0] PE = 9'h100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       ir_in = 1'b1;
    logic       glob_en = 1'b0;
    logic       rx_en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       invert = 1'b1;
    logic [5:0] noise_thr = 6'd1;
    logic [7:0] idle_thr = 8'd20;
    logic [7:0] code;
    logic       code_valid;
    logic       pkt_end;

    int checks = 0;
    int errors = 0;
    int since_tick = 1000;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    string      cur_tag = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_rl_sampler i_ir_rl_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .ir_in       (ir_in),
        .glob_en     (glob_en),
        .rx_en       (rx_en),
        .mode        (mode),
        .invert      (invert),
        .noise_thr   (noise_thr),
        .idle_thr    (idle_thr),
        .code        (code),
        .code_valid  (code_valid),
        .pkt_end     (pkt_end)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Edges since the last sampled strobe
    always @(posedge clk) begin
        if (sample_tick) since_tick <= 0;
        else if (since_tick < 1000) since_tick <= since_tick + 1;
    end

    // Monitor: pop and compare in order
    always @(negedge clk) begin
        if (rst_n && (code_valid || pkt_end)) begin
            logic [8:0] got;
            got = pkt_end ? PE : {1'b0, code};
            check(!(code_valid && pkt_end), "R8", "code and packet end together",
                  {code_valid, pkt_end}, 0);
            check(since_tick == 1, "R3", "result latency in edges after strobe",
                  since_tick, 1);
            if (exp_q.size() == 0) begin
                check(1'b0, cur_tag, "unexpected output", got, 0);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(got == e, t, "output item (0x100 = packet end)", got, e);
            end
        end
    end

    task automatic push(input logic [8:0] item, input string tag);
        exp_q.push_back(item);
        tag_q.push_back(tag);
    endtask

    task automatic drive_sample(input bit lvl);
        @(negedge clk);
        ir_in = lvl ^ invert;
        repeat (2) @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic seg(input bit lvl, input int n);
        for (int i = 0; i < n; i++) drive_sample(lvl);
    endtask

    task automatic setup(input bit g, input bit r, input logic [1:0] m,
                         input bit inv, input int nt, input int it, input string tag);
        @(negedge clk);
        glob_en = 1'b0;
        cur_tag = tag;
        invert = inv;
        ir_in = inv;
        noise_thr = 6'(nt);
        idle_thr = 8'(it);
        repeat (4) @(negedge clk);
        glob_en = g;
        rx_en = r;
        mode = m;
    endtask

    task automatic drain(input string tag);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, tag, "expected items still pending", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(code_valid == 1'b0, "R9", "code_valid in reset", code_valid, 0);
        check(pkt_end == 1'b0, "R9", "pkt_end in reset", pkt_end, 0);
        check(code == 8'h00, "R9", "code in reset", code, 0);
        rst_n = 1'b1;

        // R3: plain packet, noise 1 delays edges uniformly
        setup(1, 1, 2'b11, 1, 1, 20, "R3");
        seg(0, 5);
        push(9'h089, "R3"); push(9'h005, "R3"); push(9'h082, "R3"); push(PE, "R6");
        seg(1, 10); seg(0, 6); seg(1, 3); seg(0, 30);
        drain("R3");
        // R7: long idle after packet end emits nothing
        cur_tag = "R7";
        seg(0, 40);
        drain("R7");

        // R4: single-sample glitch absorbed
        setup(1, 1, 2'b11, 1, 1, 20, "R4");
        seg(0, 3);
        push(9'h090, "R4"); push(PE, "R6");
        seg(1, 8); seg(0, 1); seg(1, 8); seg(0, 30);
        drain("R4");

        // R5: long pulse split
        setup(1, 1, 2'b11, 1, 1, 20, "R5");
        seg(0, 3);
        push(9'h0FF, "R5"); push(9'h0FF, "R5"); push(9'h0AB, "R5"); push(PE, "R6");
        seg(1, 300); seg(0, 30);
        drain("R5");

        // R4: zero noise threshold, one-sample runs accepted
        setup(1, 1, 2'b11, 1, 0, 5, "R4");
        seg(0, 2);
        push(9'h080, "R4"); push(9'h001, "R4"); push(9'h081, "R4"); push(PE, "R6");
        seg(1, 1); seg(0, 2); seg(1, 2); seg(0, 10);
        drain("R4");

        // R2: non-inverted input
        setup(1, 1, 2'b11, 0, 1, 20, "R2");
        seg(0, 3);
        push(9'h083, "R2"); push(PE, "R6");
        seg(1, 4); seg(0, 30);
        drain("R2");

        // R6: space of idle_thr samples is a code, idle_thr+1 ends packet
        setup(1, 1, 2'b11, 1, 0, 10, "R6");
        seg(0, 2);
        push(9'h082, "R6"); push(9'h009, "R6"); push(9'h082, "R6"); push(PE, "R6");
        seg(1, 3); seg(0, 10); seg(1, 3); seg(0, 11);
        seg(0, 20);
        drain("R6");

        // R5: long space split before packet end
        setup(1, 1, 2'b11, 1, 0, 200, "R5");
        seg(0, 2);
        push(9'h081, "R5"); push(9'h07F, "R5"); push(PE, "R6");
        seg(1, 2); seg(0, 250);
        drain("R5");

        // R1: wrong mode, receive disabled, global disabled
        setup(1, 1, 2'b10, 1, 0, 5, "R1");
        seg(0, 2); seg(1, 10); seg(0, 20);
        drain("R1");
        setup(1, 0, 2'b11, 1, 0, 5, "R1");
        seg(0, 2); seg(1, 10); seg(0, 20);
        drain("R1");
        setup(0, 1, 2'b11, 1, 0, 5, "R1");
        seg(0, 2); seg(1, 10); seg(0, 20);
        drain("R1");

        // R7: re-enabled after disable starts cleanly in idle
        setup(1, 1, 2'b11, 1, 0, 5, "R7");
        seg(0, 4);
        push(9'h084, "R7"); push(PE, "R7");
        seg(1, 5); seg(0, 12);
        drain("R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule